// File: doc/BRIEF.md
# Per-Stream Scheduling State Register with Dynamic Priority Update

This block keeps the scheduling state of a single stream inside a hardware packet scheduler: its next packet arrival time, its current deadline, its request period, its loss-tolerance fraction (numerator over denominator), its stream ID and three pieces of bookkeeping (a violation flag, a drop flag and a saturating miss counter). A controller writes all service attributes in one load cycle. The block then presents a packed attribute bundle to the pairwise comparators on every cycle.

At the end of each decision cycle the controller pulses the update enable and broadcasts the ID of the winning stream. The block compares that ID with its own and checks its deadline against the current time. It then takes one of three paths: the winner update, the missed-deadline loser update, or no change for a loser that met its deadline. Both update results are computed every cycle, so the selected result is registered in the same cycle as the pulse.

Top module: `ss_stream_state`

## Requirements
- R1: After reset the attribute bundle, the violation flag, the drop flag and the miss counter are all zero.
- R2: A cycle with `load_en` high writes ID, deadline, arrival, period, numerator and denominator from the load ports, keeps the loaded numerator and denominator as the reload values, and clears violation, drop and miss counter; load takes precedence over an update in the same cycle.
- R3: On `upd_en` with `win_id` equal to the stored ID (winner), the deadline becomes deadline + period (modulo 2^16), the arrival time takes `new_arrival`, the drop flag clears, and the violation flag and miss counter keep their values.
- R4: In the winner update, if the denominator is non-zero, the denominator decrements and the numerator decrements unless it is already zero; if both results are then zero, both take their reload values. With a zero denominator the fraction is left unchanged.
- R5: On `upd_en`, a loser (ID mismatch) whose deadline is not late keeps every output unchanged.
- R6: On `upd_en`, a loser whose deadline is late gets deadline + period, takes `new_arrival` as its arrival time and sets the drop flag.
- R7: In the late-loser update, a non-zero numerator decrements and the denominator decrements if non-zero; a zero numerator instead sets the violation flag and increments the denominator, saturating at 255.
- R8: Each late-loser update increments the 16-bit miss counter, which saturates at 65535.
- R9: With the default wrap-aware time mode, the deadline is late when (now − deadline) modulo 2^16 is in 1..32767; equal times are not late.
- R10: In a cycle with neither `load_en` nor `upd_en`, no output changes.
- R11: The bundle `attr_bus` is packed as ID in bits [52:48], deadline in [47:32], arrival in [31:16], numerator in [15:8] and denominator in [7:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Load all service attributes this cycle |
| load_id | input | 5 | Stream ID to load |
| load_deadline | input | 16 | Initial deadline |
| load_arrival | input | 16 | Initial arrival time |
| load_period | input | 16 | Request period |
| load_num | input | 8 | Loss-tolerance numerator |
| load_den | input | 8 | Loss-tolerance denominator |
| upd_en | input | 1 | End-of-decision-cycle priority update pulse |
| win_id | input | 5 | Broadcast ID of the winning stream |
| now | input | 16 | Current time |
| new_arrival | input | 16 | Arrival time of the next queued packet |
| attr_bus | output | 53 | Packed attributes for the comparators |
| violated | output | 1 | Window constraint has been violated |
| drop_flag | output | 1 | Last update dropped a packet |
| miss_count | output | 16 | Saturating count of missed deadlines |

## Verification
A wrong path choice or a bad arithmetic step shows on `attr_bus` or the flags one clock after the update pulse, since every register feeds an output directly; the bench compares every output after every cycle, so a fault surfaces at the first update that exercises it. Reload values are hidden state, and a fault there only appears at the first winner update that brings both fraction fields to zero, which the random stream of wins reaches within a few tens of cycles. Saturation of the miss counter becomes visible only after 65535 misses, so a directed run drives that many consecutive late losses.

// File: rtl/ss_pkg.sv
package ss_pkg;
   typedef enum logic [1:0] {
      UPD_HOLD = 2'd0,
      UPD_WIN  = 2'd1,
      UPD_MISS = 2'd2
   } upd_path_e;
endpackage

// File: rtl/ss_late_detect.sv
module ss_late_detect #(
   parameter int TIME_W    = 16,
   parameter bit WRAP_TIME = 1'b1
) (
   input  logic [TIME_W-1:0] now,
   input  logic [TIME_W-1:0] deadline,
   output logic              late
);
   generate
      if (TIME_W < 2) begin : g_bad_width
         initial $fatal(1, "ss_late_detect: TIME_W must be at least 2");
      end
      if (WRAP_TIME) begin : g_wrap
         logic [TIME_W-1:0] diff;
         always_comb begin
            diff = now - deadline;
            late = (diff != '0) && !diff[TIME_W-1];
         end
      end else begin : g_plain
         always_comb late = (now > deadline);
      end
   endgenerate
endmodule

// File: rtl/ss_sat_inc.sv
module ss_sat_inc #(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   output logic [W-1:0] y
);
   localparam logic [W-1:0] MAXV = '1;
   generate
      if (W < 1) begin : g_bad_width
         initial $fatal(1, "ss_sat_inc: W must be positive");
      end
   endgenerate
   always_comb y = (x == MAXV) ? x : x + W'(1);
endmodule

// File: rtl/ss_next_calc.sv
module ss_next_calc #(
   parameter int TIME_W = 16,
   parameter int LOSS_W = 8
) (
   input  logic [TIME_W-1:0] deadline,
   input  logic [TIME_W-1:0] period,
   input  logic [LOSS_W-1:0] num,
   input  logic [LOSS_W-1:0] den,
   input  logic [LOSS_W-1:0] rel_num,
   input  logic [LOSS_W-1:0] rel_den,
   output logic [TIME_W-1:0] next_deadline,
   output logic [LOSS_W-1:0] win_num,
   output logic [LOSS_W-1:0] win_den,
   output logic [LOSS_W-1:0] miss_num,
   output logic [LOSS_W-1:0] miss_den,
   output logic              miss_violate
);
   logic [LOSS_W-1:0] den_up;
   logic [LOSS_W-1:0] num_dn;
   logic [LOSS_W-1:0] den_dn;

   ss_sat_inc #(.W(LOSS_W)) u_den_inc (.x(den), .y(den_up));

   always_comb begin
      next_deadline = deadline + period;
      num_dn = (num != '0) ? num - LOSS_W'(1) : num;
      den_dn = (den != '0) ? den - LOSS_W'(1) : den;
   end

   // winner path: shrink the fraction, refill from reload values when empty
   always_comb begin
      if (den == '0) begin
         win_num = num;
         win_den = den;
      end else if ((num_dn == '0) && (den_dn == '0)) begin
         win_num = rel_num;
         win_den = rel_den;
      end else begin
         win_num = num_dn;
         win_den = den_dn;
      end
   end

   // late-loser path: spend tolerance or record a violation
   always_comb begin
      if (num != '0) begin
         miss_num     = num_dn;
         miss_den     = den_dn;
         miss_violate = 1'b0;
      end else begin
         miss_num     = num;
         miss_den     = den_up;
         miss_violate = 1'b1;
      end
   end
endmodule

// File: rtl/ss_stream_state.sv
module ss_stream_state #(
   parameter int ID_W      = 5,
   parameter int TIME_W    = 16,
   parameter int LOSS_W    = 8,
   parameter int CNT_W     = 16,
   parameter bit WRAP_TIME = 1'b1,
   localparam int ATTR_W   = ID_W + 2*TIME_W + 2*LOSS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ID_W-1:0]   load_id,
   input  logic [TIME_W-1:0] load_deadline,
   input  logic [TIME_W-1:0] load_arrival,
   input  logic [TIME_W-1:0] load_period,
   input  logic [LOSS_W-1:0] load_num,
   input  logic [LOSS_W-1:0] load_den,
   input  logic              upd_en,
   input  logic [ID_W-1:0]   win_id,
   input  logic [TIME_W-1:0] now,
   input  logic [TIME_W-1:0] new_arrival,
   output logic [ATTR_W-1:0] attr_bus,
   output logic              violated,
   output logic              drop_flag,
   output logic [CNT_W-1:0]  miss_count
);
   import ss_pkg::*;

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [LOSS_W-1:0] LOSS_MAX = '1;

   generate
      if (ID_W < 1 || LOSS_W < 1 || CNT_W < 1) begin : g_bad_cfg
         initial $fatal(1, "ss_stream_state: widths must be positive");
      end
   endgenerate

   logic [ID_W-1:0]   id_q;
   logic [TIME_W-1:0] dl_q, arr_q, per_q;
   logic [LOSS_W-1:0] num_q, den_q, rnum_q, rden_q;
   logic              viol_q, drop_q;
   logic [CNT_W-1:0]  cnt_q;

   logic              late;
   logic              is_win;
   upd_path_e         path;
   logic [TIME_W-1:0] nx_dl;
   logic [LOSS_W-1:0] w_num, w_den, m_num, m_den;
   logic              m_viol;
   logic [CNT_W-1:0]  cnt_up;

   ss_late_detect #(.TIME_W(TIME_W), .WRAP_TIME(WRAP_TIME)) u_late (
      .now(now), .deadline(dl_q), .late(late)
   );

   ss_next_calc #(.TIME_W(TIME_W), .LOSS_W(LOSS_W)) u_calc (
      .deadline(dl_q), .period(per_q), .num(num_q), .den(den_q),
      .rel_num(rnum_q), .rel_den(rden_q),
      .next_deadline(nx_dl), .win_num(w_num), .win_den(w_den),
      .miss_num(m_num), .miss_den(m_den), .miss_violate(m_viol)
   );

   ss_sat_inc #(.W(CNT_W)) u_cnt_inc (.x(cnt_q), .y(cnt_up));

   always_comb begin
      is_win = (win_id == id_q);
      if (!upd_en)    path = UPD_HOLD;
      else if (is_win) path = UPD_WIN;
      else if (late)  path = UPD_MISS;
      else            path = UPD_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_q   <= '0;
         dl_q   <= '0;
         arr_q  <= '0;
         per_q  <= '0;
         num_q  <= '0;
         den_q  <= '0;
         rnum_q <= '0;
         rden_q <= '0;
         viol_q <= 1'b0;
         drop_q <= 1'b0;
         cnt_q  <= '0;
      end else if (load_en) begin
         id_q   <= load_id;
         dl_q   <= load_deadline;
         arr_q  <= load_arrival;
         per_q  <= load_period;
         num_q  <= load_num;
         den_q  <= load_den;
         rnum_q <= load_num;
         rden_q <= load_den;
         viol_q <= 1'b0;
         drop_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         unique case (path)
            UPD_WIN: begin
               dl_q   <= nx_dl;
               arr_q  <= new_arrival;
               num_q  <= w_num;
               den_q  <= w_den;
               drop_q <= 1'b0;
            end
            UPD_MISS: begin
               dl_q   <= nx_dl;
               arr_q  <= new_arrival;
               num_q  <= m_num;
               den_q  <= m_den;
               drop_q <= 1'b1;
               viol_q <= viol_q | m_viol;
               cnt_q  <= cnt_up;
            end
            default: ;
         endcase
      end
   end

   // R11: bundle layout {id, deadline, arrival, numerator, denominator}
   always_comb begin
      attr_bus   = {id_q, dl_q, arr_q, num_q, den_q};
      violated   = viol_q;
      drop_flag  = drop_q;
      miss_count = cnt_q;
   end

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (attr_bus == {$past(load_id), $past(load_deadline), $past(load_arrival),
                                $past(load_num), $past(load_den)})
                  && !violated && !drop_flag && (miss_count == '0));

   p_win_deadline_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !load_en && (win_id == attr_bus[ATTR_W-1 -: ID_W]))
      |=> (attr_bus[ATTR_W-ID_W-1 -: TIME_W] ==
           $past(attr_bus[ATTR_W-ID_W-1 -: TIME_W] + per_q)) && !drop_flag
          && $stable(miss_count));

   p_met_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !load_en && (win_id != attr_bus[ATTR_W-1 -: ID_W]) && !late)
      |=> $stable(attr_bus) && $stable(violated) && $stable(drop_flag) && $stable(miss_count));

   p_miss_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !load_en && (win_id != attr_bus[ATTR_W-1 -: ID_W]) && late)
      |=> drop_flag);

   p_den_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !load_en && (win_id != attr_bus[ATTR_W-1 -: ID_W]) && late
       && (attr_bus[2*LOSS_W-1 -: LOSS_W] == '0) && (attr_bus[LOSS_W-1:0] == LOSS_MAX))
      |=> (attr_bus[LOSS_W-1:0] == LOSS_MAX) && violated);

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && (miss_count == CNT_MAX)) |=> (miss_count == CNT_MAX));

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !upd_en) |=> $stable(attr_bus) && $stable(violated)
                                && $stable(drop_flag) && $stable(miss_count));
endmodule

// File: tb/sim_ss_stream_state.sv
module sim_ss_stream_state;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_en = 1'b0;
   logic [4:0]  load_id = '0;
   logic [15:0] load_deadline = '0, load_arrival = '0, load_period = '0;
   logic [7:0]  load_num = '0, load_den = '0;
   logic        upd_en = 1'b0;
   logic [4:0]  win_id = '0;
   logic [15:0] now = '0, new_arrival = '0;
   logic [52:0] attr_bus;
   logic        violated, drop_flag;
   logic [15:0] miss_count;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference model state
   logic [4:0]  m_id;
   logic [15:0] m_dl, m_arr, m_per;
   logic [7:0]  m_num, m_den, m_rn, m_rd;
   logic        m_v, m_d;
   logic [15:0] m_c;
   string       tag;

   always #2 clk = ~clk;

   ss_stream_state u0 (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_id(load_id),
      .load_deadline(load_deadline), .load_arrival(load_arrival),
      .load_period(load_period), .load_num(load_num), .load_den(load_den),
      .upd_en(upd_en), .win_id(win_id), .now(now), .new_arrival(new_arrival),
      .attr_bus(attr_bus), .violated(violated), .drop_flag(drop_flag),
      .miss_count(miss_count)
   );

   function automatic logic late_of(input logic [15:0] t, input logic [15:0] dl);
      logic [15:0] df = t - dl;
      return (df != 16'd0) && !df[15];
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_next();
      if (load_en) begin
         tag = "R2";
         m_id = load_id; m_dl = load_deadline; m_arr = load_arrival; m_per = load_period;
         m_num = load_num; m_den = load_den; m_rn = load_num; m_rd = load_den;
         m_v = 0; m_d = 0; m_c = 0;
      end else if (!upd_en) begin
         tag = "R10";
      end else if (win_id == m_id) begin
         tag = (m_den != 0) ? "R4" : "R3";
         m_dl = m_dl + m_per; m_arr = new_arrival; m_d = 0;
         if (m_den != 0) begin
            logic [7:0] n2, d2;
            n2 = (m_num != 0) ? m_num - 8'd1 : 8'd0;
            d2 = m_den - 8'd1;
            if (n2 == 0 && d2 == 0) begin n2 = m_rn; d2 = m_rd; end
            m_num = n2; m_den = d2;
         end
      end else if (late_of(now, m_dl)) begin
         tag = (m_num == 0) ? "R7" : "R6";
         m_dl = m_dl + m_per; m_arr = new_arrival; m_d = 1;
         if (m_c != 16'hFFFF) m_c = m_c + 16'd1;
         if (m_num != 0) begin
            m_num = m_num - 8'd1;
            if (m_den != 0) m_den = m_den - 8'd1;
         end else begin
            m_v = 1;
            if (m_den != 8'hFF) m_den = m_den + 8'd1;
         end
      end else begin
         tag = "R5";
      end
   endtask

   // drive inputs before calling; checks outputs one edge later
   task automatic tick(input string force_tag = "");
      model_next();
      if (force_tag != "") tag = force_tag;
      @(posedge clk);
      @(negedge clk);
      check({tag, "/R11 bundle"}, 64'(attr_bus), 64'({m_id, m_dl, m_arr, m_num, m_den}));
      check({tag, " violation"}, 64'(violated), 64'(m_v));
      check({tag, " drop"}, 64'(drop_flag), 64'(m_d));
      check("R8 miss counter", 64'(miss_count), 64'(m_c));
   endtask

   task automatic do_load(input logic [4:0] id, input logic [15:0] dl, input logic [15:0] arr,
                          input logic [15:0] per, input logic [7:0] num, input logic [7:0] den);
      load_en = 1; upd_en = 1; win_id = id;
      load_id = id; load_deadline = dl; load_arrival = arr; load_period = per;
      load_num = num; load_den = den;
      tick();
      load_en = 0; upd_en = 0;
   endtask

   initial begin
      int wd = 0;
      while (!done && wd < 190000) begin
         @(posedge clk);
         wd++;
      end
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      m_id = 0; m_dl = 0; m_arr = 0; m_per = 0; m_num = 0; m_den = 0;
      m_rn = 0; m_rd = 0; m_v = 0; m_d = 0; m_c = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 bundle", 64'(attr_bus), 64'd0);
      check("R1 flags", 64'({violated, drop_flag}), 64'd0);
      check("R1 counter", 64'(miss_count), 64'd0);
      rst_n = 1;

      // R2: load wins over a simultaneous update
      do_load(5'd2, 16'd100, 16'd90, 16'd10, 8'd1, 8'd2);

      // R10: idle cycle with changing inputs
      now = 16'd500; win_id = 5'd2; new_arrival = 16'h1234; tick();

      // R3/R4: winner, fraction 1/2 -> 0/1 -> reload 1/2
      upd_en = 1; win_id = 5'd2; new_arrival = 16'd111; tick();
      new_arrival = 16'd112; tick();
      new_arrival = 16'd113; tick();

      // R5: loser on time
      win_id = 5'd7; now = 16'd130; tick();
      // R5: equal time is not late (R9)
      now = m_dl; tick("R9");
      // R9: wrap-aware late detection
      do_load(5'd2, 16'hFFF0, 16'd0, 16'd4, 8'd3, 8'd5);
      upd_en = 1; win_id = 5'd9; now = 16'h0005; new_arrival = 16'd7; tick("R9");
      do_load(5'd2, 16'd5, 16'd0, 16'd4, 8'd3, 8'd5);
      upd_en = 1; win_id = 5'd9; now = 16'hFFF0; tick("R9");

      // R7: denominator saturation with zero numerator
      do_load(5'd2, 16'd0, 16'd0, 16'd0, 8'd0, 8'd253);
      upd_en = 1; win_id = 5'd3; now = 16'd1;
      repeat (4) tick();

      // R4: winner with zero denominator keeps the fraction
      do_load(5'd2, 16'd50, 16'd0, 16'd3, 8'd0, 8'd0);
      upd_en = 1; win_id = 5'd2; tick();

      // random mix
      do_load(5'd2, 16'd200, 16'd0, 16'd8, 8'd2, 8'd5);
      for (int i = 0; i < 3000; i++) begin
         int r = $urandom_range(0, 99);
         load_en = 0;
         upd_en = (r < 85);
         win_id = 5'($urandom_range(0, 3));
         now = m_dl + 16'($urandom_range(0, 24)) - 16'd12;
         new_arrival = 16'($urandom);
         if (r >= 97) begin
            load_en = 1;
            load_id = 5'd2;
            load_deadline = 16'($urandom);
            load_arrival = 16'($urandom);
            load_period = 16'($urandom_range(1, 40));
            load_num = 8'($urandom_range(0, 4));
            load_den = 8'($urandom_range(0, 8));
         end
         tick();
      end
      load_en = 0;

      // R8: miss counter saturation
      do_load(5'd2, 16'd0, 16'd0, 16'd0, 8'd0, 8'd0);
      upd_en = 1; win_id = 5'd1; now = 16'd1;
      for (int i = 0; i < 65540; i++) tick("R8");
      check("R8 saturated", 64'(miss_count), 64'hFFFF);

      upd_en = 0;
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule